// File: doc/BRIEF.md
# Hashed IPv4-to-MAC Resolution Cache

This block holds recently learned bindings from 32-bit IPv4 addresses to 48-bit MAC addresses, so that a transmit path can look up the link-layer destination of a packet without asking the network again. It has three valid/ready channels. A lookup channel carries an IP address in. A result channel returns a MAC address with a miss flag beside it. An update channel carries an IP/MAC pair to be learned. A one-cycle flush input forgets every binding at once.

The storage is direct-mapped. The slot for an address comes from a CRC-32 hash of the address. Each slot holds a valid bit, the full IP as a tag and the MAC. When a new address lands on a slot that holds a different address, the old binding is lost. Lookups and updates share the single hash unit. When both are offered in the same cycle, the lookup takes it and the update waits one cycle. A lookup therefore sees the table as it stood before the stalled update. Exactly one result is returned for each lookup, in the order the lookups were taken, and the result register is held until the consumer takes it.

Top module: `ip_mac_cache`

## Requirements
- R1: While reset is applied, and after it, no slot is valid and `rsp_valid` is 0; the first lookup after reset reports a miss.
- R2: A lookup accepted on a clock edge produces `rsp_valid`=1 after that same edge. If the address was learned and has not been lost, the result carries its MAC with `rsp_miss`=0.
- R3: A lookup of an address that is not held returns `rsp_miss`=1 with `rsp_mac` equal to zero.
- R4: The slot index is the low `AW` bits of a CRC-32 of the IP. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes the IP bits most significant first, and has no reflection and no final inversion. An update that lands on a slot holding another address replaces it: the displaced address then misses and the new one hits.
- R5: An update for an address that is already held replaces its MAC. Later lookups return the new MAC without a miss.
- R6: In a cycle where `flush` is high, `qry_ready` and `wr_ready` are both 0, and after that edge every slot is invalid. An update stalled by the flush is accepted afterwards and is kept.
- R7: `qry_ready` is 1 exactly when no result is pending or the pending result is being taken (`rsp_ready`=1). A pending result keeps `rsp_valid`, `rsp_miss` and `rsp_mac` unchanged until it is taken. Results leave in lookup order.
- R8: When a lookup is accepted in a cycle, `wr_ready` is 0 in that cycle. A lookup taken in the same cycle that an update is offered sees the table without that update.
- R9: The reset is asserted asynchronously and released through two flops. `qry_ready` and `wr_ready` stay 0 until two rising clock edges have passed after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qry_valid | input | 1 | Lookup request valid |
| qry_ready | output | 1 | Lookup request accepted |
| qry_ip | input | 32 | Address to look up |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken by consumer |
| rsp_miss | output | 1 | Address not held |
| rsp_mac | output | 48 | Resolved MAC (zero on a miss) |
| wr_valid | input | 1 | Update request valid |
| wr_ready | output | 1 | Update request accepted |
| wr_ip | input | 32 | Address to learn |
| wr_mac | input | 48 | MAC to bind to the address |
| flush | input | 1 | Invalidate all slots this cycle |

## Verification
The bench searches, with its own CRC, for addresses that share a slot. A design that indexed wrongly or compared only part of the tag would then return a stale MAC where a miss is due. A lookup and an update are offered together to show that the lookup wins and reads the table from before the update; a design that let the update through first would report a hit. A flush is raised while an update waits, to show that the update is not lost and not undone. A design that cleared after writing would drop it, and one that accepted writes during flush would let the table survive. The result channel is held back for several cycles while a second lookup waits, which catches results that change, get dropped or come out of order.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int IP_W  = 32;
  localparam int MAC_W = 48;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic [IP_W-1:0]  ip;
    logic [MAC_W-1:0] mac;
  } ipc_entry_t;

  // CRC-32 of one 32-bit word, MSB first, seed all ones, no reflection.
  function automatic logic [31:0] crc_word(input logic [31:0] d);
    logic [31:0] r;
    r = '1;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  // Input bits whose parity forms output bit obit (linear part of the CRC).
  function automatic logic [31:0] crc_tap_mask(input int obit);
    logic [31:0] m;
    logic [31:0] base;
    logic [31:0] one;
    base = crc_word('0);
    for (int i = 0; i < 32; i++) begin
      one  = crc_word(32'h1 << i);
      m[i] = one[obit] ^ base[obit];
    end
    return m;
  endfunction

endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/ipc_hash.sv
module ipc_hash #(
  parameter int AW = 2
) (
  input  logic [31:0]   key,
  output logic [AW-1:0] idx
);
  import ipc_pkg::*;

  localparam logic [31:0] SEED_TERM = crc_word('0);

  // Each index bit is the parity of a fixed tap set of the key, plus a
  // constant from the all-ones seed.
  for (genvar j = 0; j < AW; j++) begin : g_bit
    localparam logic [31:0] TAPS = crc_tap_mask(j);
    assign idx[j] = (^(key & TAPS)) ^ SEED_TERM[j];
  end

endmodule

// File: rtl/ipc_store.sv
module ipc_store #(
  parameter int AW = 2
) (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic                     clr,
  input  logic                     we,
  input  logic [AW-1:0]            idx,
  input  logic [ipc_pkg::IP_W-1:0]  wip,
  input  logic [ipc_pkg::MAC_W-1:0] wmac,
  output logic                     rd_valid,
  output logic [ipc_pkg::IP_W-1:0]  rd_ip,
  output logic [ipc_pkg::MAC_W-1:0] rd_mac,
  output logic [(1<<AW)-1:0]       ent_valid
);
  import ipc_pkg::*;

  localparam int NE = 1 << AW;

  logic [NE-1:0] valid_q;
  logic [NE-1:0] valid_d;
  logic [NE-1:0] slot_sel;
  ipc_entry_t    ent_q [NE];
  ipc_entry_t    rd_ent;

  for (genvar e = 0; e < NE; e++) begin : g_slot
    assign slot_sel[e] = we && !clr && (idx == AW'(e));

    always_ff @(posedge clk) begin
      if (slot_sel[e]) ent_q[e] <= '{ip: wip, mac: wmac};
    end
  end

  // Flush wins over any write in the same cycle.
  always_comb begin
    if (clr) valid_d = '0;
    else     valid_d = valid_q | slot_sel;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  assign rd_ent    = ent_q[idx];
  assign rd_valid  = valid_q[idx];
  assign rd_ip     = rd_ent.ip;
  assign rd_mac    = rd_ent.mac;
  assign ent_valid = valid_q;

endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl (
  input  logic                     clk,
  input  logic                     rst_sn,
  input  logic                     qry_valid,
  output logic                     qry_ready,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     flush,
  input  logic                     rsp_ready,
  input  logic                     hit,
  input  logic [ipc_pkg::MAC_W-1:0] hit_mac,
  output logic                     q_fire,
  output logic                     w_fire,
  output logic                     rsp_valid,
  output logic                     rsp_miss,
  output logic [ipc_pkg::MAC_W-1:0] rsp_mac
);
  import ipc_pkg::*;

  logic             rv_q, rv_d;
  logic             miss_q, miss_d;
  logic [MAC_W-1:0] mac_q, mac_d;
  logic             load_en;

  // Lookup has the hash unit first; updates take the idle cycles.
  assign qry_ready = rst_sn && !flush && (!rv_q || rsp_ready);
  assign q_fire    = qry_valid && qry_ready;
  assign wr_ready  = rst_sn && !flush && !q_fire;
  assign w_fire    = wr_valid && wr_ready;
  assign load_en   = q_fire;

  always_comb begin
    rv_d   = rv_q;
    miss_d = miss_q;
    mac_d  = mac_q;
    if (q_fire) begin
      rv_d   = 1'b1;
      miss_d = !hit;
      mac_d  = hit ? hit_mac : '0;
    end else if (rsp_ready) begin
      rv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rv_q <= 1'b0;
    else         rv_q <= rv_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      miss_q <= miss_d;
      mac_q  <= mac_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_miss  = miss_q;
  assign rsp_mac   = mac_q;

endmodule

// File: rtl/ip_mac_cache.sv
module ip_mac_cache #(
  parameter int AW = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        qry_valid,
  output logic        qry_ready,
  input  logic [31:0] qry_ip,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_miss,
  output logic [47:0] rsp_mac,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [31:0] wr_ip,
  input  logic [47:0] wr_mac,
  input  logic        flush
);
  import ipc_pkg::*;

  localparam int NE = 1 << AW;

  logic             rst_sn;
  logic             q_fire, w_fire;
  logic [31:0]      hash_key;
  logic [AW-1:0]    slot;
  logic             rd_valid;
  logic [IP_W-1:0]  rd_ip;
  logic [MAC_W-1:0] rd_mac;
  logic             hit;
  logic [NE-1:0]    ent_valid;

  ipc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign hash_key = q_fire ? qry_ip : wr_ip;

  ipc_hash #(.AW(AW)) u_hash (
    .key (hash_key),
    .idx (slot)
  );

  ipc_store #(.AW(AW)) u_store (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .clr       (flush),
    .we        (w_fire),
    .idx       (slot),
    .wip       (wr_ip),
    .wmac      (wr_mac),
    .rd_valid  (rd_valid),
    .rd_ip     (rd_ip),
    .rd_mac    (rd_mac),
    .ent_valid (ent_valid)
  );

  assign hit = rd_valid && (rd_ip == qry_ip);

  ipc_ctrl u_ctrl (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .qry_valid (qry_valid),
    .qry_ready (qry_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .flush     (flush),
    .rsp_ready (rsp_ready),
    .hit       (hit),
    .hit_mac   (rd_mac),
    .q_fire    (q_fire),
    .w_fire    (w_fire),
    .rsp_valid (rsp_valid),
    .rsp_miss  (rsp_miss),
    .rsp_mac   (rsp_mac)
  );

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int AW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              qry_valid,
  input logic              qry_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_miss,
  input logic [47:0]       rsp_mac,
  input logic              wr_ready,
  input logic              flush,
  input logic [(1<<AW)-1:0] ent_valid
);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_miss) && $stable(rsp_mac));

  p_no_accept_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !qry_ready);

  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid && qry_ready |=> rsp_valid);

  p_query_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid && qry_ready |-> !wr_ready);

  p_flush_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !qry_ready && !wr_ready);

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ent_valid == '0);

  p_miss_zero_mac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_mac == '0);

endmodule

bind ip_mac_cache ipc_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .qry_valid (qry_valid),
  .qry_ready (qry_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_miss  (rsp_miss),
  .rsp_mac   (rsp_mac),
  .wr_ready  (wr_ready),
  .flush     (flush),
  .ent_valid (ent_valid)
);

// File: tb/sim_ip_mac_cache.sv
module sim_ip_mac_cache;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;
  localparam int NE = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qry_valid = 1'b0;
  logic [31:0] qry_ip = '0;
  logic        rsp_ready = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_ip = '0;
  logic [47:0] wr_mac = '0;
  logic        flush = 1'b0;
  logic        qry_ready, rsp_valid, rsp_miss, wr_ready;
  logic [47:0] rsp_mac;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  ip_mac_cache #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_ip(qry_ip),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_miss(rsp_miss), .rsp_mac(rsp_mac),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ip(wr_ip), .wr_mac(wr_mac),
    .flush(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  bit          m_val [NE];
  logic [31:0] m_tag [NE];
  logic [47:0] m_mac [NE];
  bit          m_rv = 1'b0;
  bit          m_rmiss = 1'b0;
  logic [47:0] m_rmac = '0;
  int          m_cnt = 0;
  bit          e_q, e_w;
  int          m_i;

  function automatic int slot_of(input logic [31:0] ip);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] ^ ip[b]) r = (r << 1) ^ 32'h04C1_1DB7;
      else               r = r << 1;
    end
    return int'(r) & (NE - 1);
  endfunction

  function automatic bit exp_qry_ready();
    return (m_cnt >= 2) && !flush && (!m_rv || rsp_ready);
  endfunction

  function automatic bit exp_wr_ready(input bit qr);
    return (m_cnt >= 2) && !flush && !(qry_valid && qr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_rv  = 1'b0;
      for (int k = 0; k < NE; k++) m_val[k] = 1'b0;
    end else begin
      e_q = exp_qry_ready();
      e_w = exp_wr_ready(e_q);
      if (m_cnt < 2) begin
        m_cnt++;
        m_rv = 1'b0;
        for (int k = 0; k < NE; k++) m_val[k] = 1'b0;
      end else begin
        if (qry_valid && e_q) begin
          m_i = slot_of(qry_ip);
          m_rv = 1'b1;
          if (m_val[m_i] && m_tag[m_i] == qry_ip) begin
            m_rmiss = 1'b0; m_rmac = m_mac[m_i];
          end else begin
            m_rmiss = 1'b1; m_rmac = '0;
          end
        end else if (rsp_ready) begin
          m_rv = 1'b0;
        end
        if (flush) begin
          for (int k = 0; k < NE; k++) m_val[k] = 1'b0;
        end else if (wr_valid && e_w) begin
          m_i = slot_of(wr_ip);
          m_val[m_i] = 1'b1; m_tag[m_i] = wr_ip; m_mac[m_i] = wr_mac;
        end
      end
      cmp_on = 1'b1;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R7/R9 model qry_ready", 64'(qry_ready), 64'(exp_qry_ready()));
      chk("R8/R9 model wr_ready", 64'(wr_ready), 64'(exp_wr_ready(exp_qry_ready())));
      chk("R2 model rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk("R2 model rsp_miss", 64'(rsp_miss), 64'(m_rmiss));
        chk("R2 model rsp_mac", 64'(rsp_mac), 64'(m_rmac));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_write(input logic [31:0] ip, input logic [47:0] mac);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_ip = ip; wr_mac = mac;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_query(input logic [31:0] ip, input bit miss, input logic [47:0] mac,
                          input string req);
    @(posedge clk); #1;
    qry_valid = 1'b1; qry_ip = ip;
    do @(negedge clk); while (!qry_ready);
    @(posedge clk); #1;
    qry_valid = 1'b0;
    @(negedge clk);
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " rsp_miss"}, 64'(rsp_miss), 64'(miss));
    chk({req, " rsp_mac"}, 64'(rsp_mac), 64'(mac));
  endtask

  logic [31:0] ip_a, ip_b, ip_c, ip_d, ip_e;

  initial begin
    ip_a = 32'hC0A8_0111;
    ip_b = '0; ip_c = '0;
    for (int k = 1; k < 4000; k++) begin
      if (ip_c == '0 && slot_of(ip_a + k) == slot_of(ip_a)) ip_c = ip_a + k;
      if (ip_b == '0 && slot_of(ip_a + k) != slot_of(ip_a)) ip_b = ip_a + k;
    end
    ip_d = 32'h0A00_0005;
    ip_e = 32'h0A00_0009;

    // R1 / R9: reset and synchronous release
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R9 qry_ready in reset", 64'(qry_ready), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 qry_ready after one edge", 64'(qry_ready), 64'd0);
    chk("R9 wr_ready after one edge", 64'(wr_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 qry_ready after two edges", 64'(qry_ready), 64'd1);
    chk("R9 wr_ready after two edges", 64'(wr_ready), 64'd1);

    // R1 / R3: empty table misses with zero MAC
    do_query(ip_a, 1'b1, 48'h0, "R1 R3 empty lookup");

    // R2: learn two addresses in different slots and read both back
    do_write(ip_a, 48'h0000_C0A8_0111);
    do_write(ip_b, 48'h0000_AAAA_0002);
    do_query(ip_a, 1'b0, 48'h0000_C0A8_0111, "R2 hit a");
    do_query(ip_b, 1'b0, 48'h0000_AAAA_0002, "R2 hit b");
    do_query(ip_d, 1'b1, 48'h0, "R3 unknown d");

    // R4: colliding address evicts the occupant
    do_write(ip_c, 48'h0000_CCCC_0003);
    do_query(ip_a, 1'b1, 48'h0, "R4 evicted a");
    do_query(ip_c, 1'b0, 48'h0000_CCCC_0003, "R4 new c");
    do_query(ip_b, 1'b0, 48'h0000_AAAA_0002, "R4 other slot b");

    // R5: in-place update
    do_write(ip_c, 48'h0000_CCCC_0064);
    do_query(ip_c, 1'b0, 48'h0000_CCCC_0064, "R5 updated c");

    // R7: back-pressure with a second lookup waiting
    @(posedge clk); #1;
    rsp_ready = 1'b0; qry_valid = 1'b1; qry_ip = ip_a;
    @(negedge clk);
    chk("R7 accept when idle", 64'(qry_ready), 64'd1);
    @(posedge clk); #1;
    qry_ip = ip_c;
    @(negedge clk);
    chk("R7 first result miss", 64'(rsp_miss), 64'd1);
    chk("R7 blocked while pending", 64'(qry_ready), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 result held valid", 64'(rsp_valid), 64'd1);
    chk("R7 result held miss", 64'(rsp_miss), 64'd1);
    chk("R7 still blocked", 64'(qry_ready), 64'd0);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R7 accept while draining", 64'(qry_ready), 64'd1);
    @(posedge clk); #1;
    qry_valid = 1'b0;
    @(negedge clk);
    chk("R7 second result in order", 64'(rsp_mac), 64'h0000_CCCC_0064);
    chk("R7 second result hit", 64'(rsp_miss), 64'd0);

    // R8: lookup and update offered together
    @(posedge clk); #1;
    qry_valid = 1'b1; qry_ip = ip_d;
    wr_valid = 1'b1; wr_ip = ip_d; wr_mac = 48'h0000_DDDD_0004;
    @(negedge clk);
    chk("R8 lookup taken", 64'(qry_ready), 64'd1);
    chk("R8 update stalled", 64'(wr_ready), 64'd0);
    @(posedge clk); #1;
    qry_valid = 1'b0;
    @(negedge clk);
    chk("R8 lookup saw old table", 64'(rsp_miss), 64'd1);
    chk("R8 update now taken", 64'(wr_ready), 64'd1);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    do_query(ip_d, 1'b0, 48'h0000_DDDD_0004, "R8 update landed");

    // R6: flush with an update and a lookup waiting
    @(posedge clk); #1;
    flush = 1'b1;
    wr_valid = 1'b1; wr_ip = ip_e; wr_mac = 48'h0000_EEEE_0005;
    qry_valid = 1'b1; qry_ip = ip_d;
    @(negedge clk);
    chk("R6 lookup blocked by flush", 64'(qry_ready), 64'd0);
    chk("R6 update blocked by flush", 64'(wr_ready), 64'd0);
    @(posedge clk); #1;
    flush = 1'b0;
    @(negedge clk);
    chk("R6 lookup after flush", 64'(qry_ready), 64'd1);
    @(posedge clk); #1;
    qry_valid = 1'b0;
    @(negedge clk);
    chk("R6 d gone after flush", 64'(rsp_miss), 64'd1);
    chk("R6 update taken after flush", 64'(wr_ready), 64'd1);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    do_query(ip_e, 1'b0, 48'h0000_EEEE_0005, "R6 stalled update kept");
    do_query(ip_c, 1'b1, 48'h0, "R6 c gone after flush");
    do_query(ip_b, 1'b1, 48'h0, "R6 b gone after flush");

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule